// File: doc/BRIEF.md
# Address Breakpoint Interrupt Generator

This block watches the address bus of a 16-bit processor. When the bus carries an address that software has programmed, it raises a break request. Software loads the target address through a small byte-wide register port as two bytes, one upper and one lower, and sets an enable bit in a control byte. Each byte of the bus address is compared separately against its register. A break is requested only when both comparisons hit, the block is enabled, and the bus qualifier marks the address as valid.

The processor must not be interrupted in the middle of an instruction. A hit seen before an instruction's last cycle is therefore held as pending, and it is taken on the next cycle flagged as an instruction boundary. A hit on a boundary cycle is taken in that same cycle. When the break is taken, the block pulses a request for one cycle. The processor uses that pulse to force a software-interrupt opcode into its instruction stream. It reads the vector location from the block's vector output, and that location moves to a second page when monitor mode is on.

A taken break sets an active flag in the control byte. While the flag is set, no new break is recognised. Software clears the flag by writing 0 to it, but only when a flag-clear permission input allows it.

Top module: `brk_top`

## Requirements
- R1: After reset, every register selection reads 0x00 and `breakReq` is low.
- R2: `regSel` 0 selects the upper address byte (bus bits 15:8), 1 the lower byte (bits 7:0), 2 the control byte and 3 nothing (reads 0x00). Writes take effect at the clock edge where `regWrEn` is high. In the control byte, bit 7 is the enable (read/write) and bit 6 is the active flag, which software cannot set. Bits 5:0 always read 0.
- R3: A hit needs both byte comparisons to match and the enable bit to be 1. An address that matches only one byte, or any match while disabled, produces no break.
- R4: A hit on a cycle with `instrLast` low is held pending. `breakReq` then rises in the next cycle with `instrLast` high, whatever the bus carries in that cycle.
- R5: A hit on a cycle with `instrLast` high raises `breakReq` combinationally in that same cycle.
- R6: `breakReq` is high for exactly one cycle per break, and the active flag (control bit 6) reads 1 from the following cycle on.
- R7: While the active flag is 1, a matching address raises no `breakReq`.
- R8: During a break, `breakVector` is 0xFFFC with `monitorMode` low and 0xFEFC with `monitorMode` high.
- R9: Writing 0 to control bit 6 clears the active flag only when `flagClrEn` is 1. With `flagClrEn` at 0, the flag stays 1.
- R10: Writing 0 to the enable bit discards a pending break. The break is not taken at a later boundary, even after the block is re-enabled.
- R11: With `busAddrValid` low, a matching address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 2 | Register selection for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| busAddr | input | 16 | Processor address bus |
| busAddrValid | input | 1 | Qualifies `busAddr` for comparison |
| instrLast | input | 1 | High on the last cycle of an instruction |
| monitorMode | input | 1 | Selects the monitor-page vector |
| flagClrEn | input | 1 | Permits software to clear the active flag |
| breakReq | output | 1 | One-cycle break request to the processor |
| breakVector | output | 16 | Address of the vector's upper byte |

## Verification
The bench builds the block with its default 8-bit register width, so the bus is 16 bits wide and splits into two byte comparators. This width brings single-byte near misses within reach: an address that matches the upper register but not the lower, and the reverse, must both be rejected. The default vector values let the two monitor-mode locations be checked directly. The bench also covers boundary-driven deferral and cancellation of a pending break through the enable bit.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrHi;
    logic wrLo;
  } dpStrobes_t;

  localparam int EN_BIT  = 7;
  localparam int ACT_BIT = 6;

endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] NORMAL_VEC  = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] MONITOR_VEC = 16'hFEFC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            strobes,
  input  logic [1:0]            regSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [2*DATA_W-1:0]   busAddr,
  input  logic                  busAddrValid,
  input  logic                  monitorMode,
  output logic                  addrHit,
  output logic [DATA_W-1:0]     addrRdData,
  output logic [2*DATA_W-1:0]   breakVector
);

  localparam int NUM_SLICES = 2;

  logic [NUM_SLICES-1:0]  sliceWr;
  logic [NUM_SLICES-1:0]  sliceEq;
  logic [DATA_W-1:0]      sliceReg [NUM_SLICES];

  // slice 0 = lower byte, slice 1 = upper byte
  assign sliceWr = {strobes.wrHi, strobes.wrLo};

  for (genvar g = 0; g < NUM_SLICES; g++) begin : gSlice
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sliceReg[g] <= '0;
      else if (sliceWr[g])
        sliceReg[g] <= wrData;
    end

    assign sliceEq[g] = (busAddr[g*DATA_W +: DATA_W] == sliceReg[g]);

    p_slice_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      sliceWr[g] |=> (sliceReg[g] == $past(wrData)));
  end

  assign addrHit = busAddrValid && (&sliceEq);

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_HI:  addrRdData = sliceReg[1];
      SEL_LO:  addrRdData = sliceReg[0];
      default: addrRdData = '0;
    endcase
  end

  assign breakVector = monitorMode ? MONITOR_VEC : NORMAL_VEC;

  p_valid_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busAddrValid |-> !addrHit);

endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic              wrEnBit,
  input  logic              wrActBit,
  input  logic              flagClrEn,
  input  logic              addrHit,
  input  logic              instrLast,
  output dpStrobes_t        strobes,
  output logic [DATA_W-1:0] ctrlRdData,
  output logic              breakReq
);

  logic enable;
  logic active;
  logic pending;
  logic wrCtrl;
  logic armed;
  logic takeNow;
  logic cancel;

  assign wrCtrl       = regWrEn && (regSel_e'(regSel) == SEL_CTRL);
  assign strobes.wrHi = regWrEn && (regSel_e'(regSel) == SEL_HI);
  assign strobes.wrLo = regWrEn && (regSel_e'(regSel) == SEL_LO);

  assign armed   = enable && !active;
  assign takeNow = armed && instrLast && (pending || addrHit);
  assign cancel  = wrCtrl && !wrEnBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      active  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (wrCtrl)
        enable <= wrEnBit;

      if (takeNow)
        active <= 1'b1;
      else if (wrCtrl && !wrActBit && flagClrEn)
        active <= 1'b0;

      if (cancel || takeNow)
        pending <= 1'b0;
      else if (armed && addrHit && !instrLast)
        pending <= 1'b1;
    end
  end

  always_comb begin
    ctrlRdData = '0;
    if (regSel_e'(regSel) == SEL_CTRL) begin
      ctrlRdData[EN_BIT]  = enable;
      ctrlRdData[ACT_BIT] = active;
    end
  end

  assign breakReq = takeNow;

  p_req_on_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> instrLast);

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |=> !breakReq);

  p_sets_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |=> active);

  p_quiet_when_active_r7: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !breakReq);

  p_needs_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !breakReq);

  p_protected_r9: assert property (@(posedge clk) disable iff (!rstN)
    (active && !flagClrEn) |=> active);

  p_cancel_r10: assert property (@(posedge clk) disable iff (!rstN)
    cancel |=> !breakReq);

endmodule

// File: rtl/brk_top.sv
module brk_top
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] NORMAL_VEC  = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] MONITOR_VEC = 16'hFEFC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regSel,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [2*DATA_W-1:0] busAddr,
  input  logic                busAddrValid,
  input  logic                instrLast,
  input  logic                monitorMode,
  input  logic                flagClrEn,
  output logic                breakReq,
  output logic [2*DATA_W-1:0] breakVector
);

  dpStrobes_t        strobes;
  logic              addrHit;
  logic [DATA_W-1:0] addrRdData;
  logic [DATA_W-1:0] ctrlRdData;

  brk_control #(.DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .regWrEn    (regWrEn),
    .wrEnBit    (regWrData[EN_BIT]),
    .wrActBit   (regWrData[ACT_BIT]),
    .flagClrEn  (flagClrEn),
    .addrHit    (addrHit),
    .instrLast  (instrLast),
    .strobes    (strobes),
    .ctrlRdData (ctrlRdData),
    .breakReq   (breakReq)
  );

  brk_datapath #(
    .DATA_W      (DATA_W),
    .NORMAL_VEC  (NORMAL_VEC),
    .MONITOR_VEC (MONITOR_VEC)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regSel       (regSel),
    .wrData       (regWrData),
    .busAddr      (busAddr),
    .busAddrValid (busAddrValid),
    .monitorMode  (monitorMode),
    .addrHit      (addrHit),
    .addrRdData   (addrRdData),
    .breakVector  (breakVector)
  );

  assign regRdData = addrRdData | ctrlRdData;

endmodule

// File: tb/tb_brk_top.sv
module tb_brk_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [15:0] busAddr = 16'h0000;
  logic        busAddrValid = 1'b0;
  logic        instrLast = 1'b0;
  logic        monitorMode = 1'b0;
  logic        flagClrEn = 1'b1;
  logic        breakReq;
  logic [15:0] breakVector;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  brk_top dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busAddr(busAddr),
    .busAddrValid(busAddrValid), .instrLast(instrLast),
    .monitorMode(monitorMode), .flagClrEn(flagClrEn),
    .breakReq(breakReq), .breakVector(breakVector)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 2'd3;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1 val = regRdData;
    regSel = 2'd3;
  endtask

  task automatic cyc(input logic [15:0] a, input logic v, input logic last,
                     output logic req, output logic [15:0] vec);
    busAddr = a; busAddrValid = v; instrLast = last;
    #1 req = breakReq; vec = breakVector;
    @(negedge clk);
    busAddrValid = 1'b0; instrLast = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    for (int s = 0; s < 4; s++) begin
      readReg(s[1:0], v);
      chk("R1 reset read", {8'h0, v}, 16'h0000);
    end
    chk("R1 reset breakReq", {15'h0, breakReq}, 16'h0000);
  endtask

  task automatic tRegs();
    logic [7:0] v;
    writeReg(2'd0, 8'h12);
    writeReg(2'd1, 8'h34);
    readReg(2'd0, v); chk("R2 upper byte", {8'h0, v}, 16'h0012);
    readReg(2'd1, v); chk("R2 lower byte", {8'h0, v}, 16'h0034);
    writeReg(2'd2, 8'hFF);
    readReg(2'd2, v); chk("R2 ctrl write ones", {8'h0, v}, 16'h0080);
    readReg(2'd3, v); chk("R2 unused select", {8'h0, v}, 16'h0000);
    writeReg(2'd2, 8'h00);
    readReg(2'd2, v); chk("R2 ctrl cleared", {8'h0, v}, 16'h0000);
  endtask

  task automatic tMatch();
    logic r; logic [15:0] vec; logic [7:0] v;
    cyc(16'h1234, 1, 1, r, vec); chk("R3 disabled no break", {15'h0, r}, 16'h0);
    writeReg(2'd2, 8'h80);
    cyc(16'h1299, 1, 1, r, vec); chk("R3 lower miss", {15'h0, r}, 16'h0);
    cyc(16'h9934, 1, 1, r, vec); chk("R3 upper miss", {15'h0, r}, 16'h0);
    cyc(16'h1234, 0, 1, r, vec); chk("R11 invalid ignored", {15'h0, r}, 16'h0);
    readReg(2'd2, v); chk("R11 active still clear", {8'h0, v}, 16'h0080);
    cyc(16'h1234, 1, 1, r, vec); chk("R5 immediate break", {15'h0, r}, 16'h1);
    chk("R8 normal vector", vec, 16'hFFFC);
    readReg(2'd2, v); chk("R6 active set", {8'h0, v}, 16'h00C0);
    cyc(16'h1234, 1, 1, r, vec); chk("R7 no break while active", {15'h0, r}, 16'h0);
    writeReg(2'd2, 8'h80);
    readReg(2'd2, v); chk("R9 cleared with permission", {8'h0, v}, 16'h0080);
  endtask

  task automatic tDefer();
    logic r; logic [15:0] vec; logic [7:0] v;
    cyc(16'h1234, 1, 0, r, vec); chk("R4 mid-instruction no break", {15'h0, r}, 16'h0);
    cyc(16'h0000, 0, 0, r, vec); chk("R4 still deferred", {15'h0, r}, 16'h0);
    cyc(16'h0000, 0, 1, r, vec); chk("R4 taken at boundary", {15'h0, r}, 16'h1);
    cyc(16'h0000, 0, 1, r, vec); chk("R6 single cycle", {15'h0, r}, 16'h0);
    writeReg(2'd2, 8'h80);
    readReg(2'd2, v); chk("R4 flag cleared", {8'h0, v}, 16'h0080);
  endtask

  task automatic tProtect();
    logic r; logic [15:0] vec; logic [7:0] v;
    cyc(16'h1234, 1, 1, r, vec); chk("R9 break for protect", {15'h0, r}, 16'h1);
    flagClrEn = 1'b0;
    writeReg(2'd2, 8'h80);
    readReg(2'd2, v); chk("R9 protected flag kept", {8'h0, v}, 16'h00C0);
    flagClrEn = 1'b1;
    writeReg(2'd2, 8'h80);
    readReg(2'd2, v); chk("R9 flag cleared", {8'h0, v}, 16'h0080);
  endtask

  task automatic tMonitor();
    logic r; logic [15:0] vec;
    monitorMode = 1'b1;
    cyc(16'h1234, 1, 1, r, vec); chk("R8 monitor break", {15'h0, r}, 16'h1);
    chk("R8 monitor vector", vec, 16'hFEFC);
    monitorMode = 1'b0;
    writeReg(2'd2, 8'h80);
  endtask

  task automatic tCancel();
    logic r; logic [15:0] vec;
    cyc(16'h1234, 1, 0, r, vec); chk("R10 pending set", {15'h0, r}, 16'h0);
    writeReg(2'd2, 8'h00);
    writeReg(2'd2, 8'h80);
    cyc(16'h0000, 0, 1, r, vec); chk("R10 cancelled pending", {15'h0, r}, 16'h0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    writeReg(2'd0, 8'h12);
    writeReg(2'd1, 8'h34);
    tMatch();
    tDefer();
    tProtect();
    tMonitor();
    tCancel();
    repeat (2) @(negedge clk);
    finish();
  end

endmodule